// File: doc/BRIEF.md
# I2C Wiper Register Slave

This block is the serial front end of a one-time-programmable trimming element. It listens on an I2C-compatible two-wire bus and gives a host write and read access to a 6-bit wiper code held by a neighbouring fuse sequencer. The block runs entirely from the system clock. SCL and SDA pass through two-flop synchronisers and edge detectors, and the slave pulls SDA low through an open-drain output enable. It never stretches the clock.

A write transfer carries three kinds of byte. The address byte holds a fixed 6-bit prefix, one pin-strapped bit and R/W=0. The instruction byte has a program flag in its MSB. Each data byte that follows carries a wiper code in its six low bits. With the program flag clear, every data byte becomes a one-cycle load request, unless the sequencer reports the locked status. With the flag set, every data byte becomes a one-cycle program request. A read transfer (R/W=1) has no instruction byte. Each byte the slave returns holds the 2-bit validation status in its two top bits and the wiper code below them. The slave reloads a fresh snapshot for every byte that the master acknowledges.

The FSM states are IDLE (bus free), ADDR (shift in the address), ADDR_ACK, INSTR (shift in the instruction), INSTR_ACK, DATA (shift in a data byte), DATA_ACK, TX (drive a status/code byte), TX_MACK (watch the master's acknowledge) and SKIP (ignore the bus until the next START or STOP). The transitions are as follows:
- A START goes to ADDR from any state, and a STOP goes to IDLE from any state.
- ADDR goes to ADDR_ACK on a match and to SKIP on a mismatch, at the SCL fall that follows the 8th bit.
- ADDR_ACK goes to INSTR for a write and to TX for a read.
- INSTR goes to INSTR_ACK, and INSTR_ACK goes to DATA.
- DATA goes to DATA_ACK, which issues the request, and DATA_ACK goes back to DATA.
- TX goes to TX_MACK after 8 bits.
- TX_MACK goes back to TX after a master ACK and to SKIP after a NACK.

Top module: `wiper_i2c_slave`

## Requirements
- R1: The address byte is sent MSB first as bits [7:2]=010110, bit [1]=addr_pin, bit [0]=R/W (0 write, 1 read). On a match the slave drives SDA low for the 9th clock pulse.
- R2: After an address that does not match, the slave drives SDA for no bit at all until the next START, and it issues no request.
- R3: In a write, the slave acknowledges the instruction byte and each data byte. With instruction bit 7 = 0 and status_i not 2'b11, each data byte gives one wr_req pulse with req_code = data[5:0].
- R4: With instruction bit 7 = 1, each data byte gives one prog_req pulse with req_code = data[5:0], and no wr_req.
- R5: When status_i = 2'b11 (locked) at the moment a data byte completes, a write with bit 7 = 0 gives no wr_req. The bytes are still acknowledged.
- R6: Further data bytes in the same transfer each repeat the request chosen by that transfer's instruction byte.
- R7: In a read, the slave drives {status_i[1:0], wiper_i[5:0]} MSB first, starting right after the address acknowledge. The values are captured at the start of each byte. After each master ACK, another byte follows.
- R8: A master NACK after a read byte ends the read. SDA stays released until the next START.
- R9: A START at any point restarts address matching. A STOP at any point returns to idle and releases SDA. A transfer cut short by either issues no request.
- R10: wr_req and prog_req are never high in the same cycle, and each lasts one cycle.
- R11: After reset, sda_oe, wr_req and prog_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pin | input | 1 | Pin-strapped address bit |
| status_i | input | 2 | Validation status from the fuse sequencer (2'b11 = locked) |
| wiper_i | input | 6 | Current wiper code from the fuse sequencer |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wr_req | output | 1 | One-cycle wiper load request |
| prog_req | output | 1 | One-cycle permanent programming request |
| req_code | output | 6 | Code carried by wr_req or prog_req |

## Verification
Two events can fall in the same cycle. One is the data-byte completion, where the slave chooses between a load request and no request. The other is a change of the lock status reported by the sequencer. The bench provokes this by flipping status_i to locked, and later back to unlocked, right at the SCL fall that ends the 8th data bit. The decision takes place a few clock cycles later, inside that window. The bench judges the outcome only by the count of wr_req pulses: none while locked, exactly one with the right code once unlocked.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_INSTR,
        S_INSTR_ACK,
        S_DATA,
        S_DATA_ACK,
        S_TX,
        S_TX_MACK,
        S_SKIP
    } wpi_state_e;
endpackage

// File: rtl/wpi_sync.sv
module wpi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/wpi_fsm.sv
module wpi_fsm
    import wpi_pkg::*;
#(
    parameter int                  PREFIX_W    = 6,
    parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 6'b010110,
    parameter int                  CODE_W      = 6,
    parameter int                  STAT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic              addr_pin,
    input  logic [STAT_W-1:0] status_i,
    input  logic [CODE_W-1:0] wiper_i,
    output logic              sda_oe,
    output logic              wr_req,
    output logic              prog_req,
    output logic [CODE_W-1:0] req_code
);
    localparam int                BYTE_W = STAT_W + CODE_W;
    localparam int                CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  FULL   = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(BYTE_W - 1);
    localparam logic [STAT_W-1:0] LOCKED = '1;

    wpi_state_e        state_q, state_n;
    logic [BYTE_W-1:0] shreg_q, shreg_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              tflag_q, tflag_n;
    logic              mack_q, mack_n;
    logic              wr_q, wr_n, prog_q, prog_n;
    logic [CODE_W-1:0] code_q, code_n;
    logic              start_det, stop_det, rx_state;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign rx_state  = (state_q == S_ADDR) || (state_q == S_INSTR) || (state_q == S_DATA);

    // next-state and datapath decisions
    always_comb begin
        state_n = state_q;
        shreg_n = shreg_q;
        cnt_n   = cnt_q;
        tflag_n = tflag_q;
        mack_n  = mack_q;
        code_n  = code_q;
        wr_n    = 1'b0;
        prog_n  = 1'b0;
        if (start_det) begin
            state_n = S_ADDR;
            cnt_n   = '0;
        end else if (stop_det) begin
            state_n = S_IDLE;
            cnt_n   = '0;
        end else if (rx_state) begin
            if (scl_rise && cnt_q != FULL) begin
                shreg_n = {shreg_q[BYTE_W-2:0], sda_lvl};
                cnt_n   = cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == FULL) begin
                cnt_n = '0;
                if (state_q == S_ADDR) begin
                    state_n = (shreg_q[BYTE_W-1:1] == {ADDR_PREFIX, addr_pin}) ? S_ADDR_ACK : S_SKIP;
                end else if (state_q == S_INSTR) begin
                    tflag_n = shreg_q[BYTE_W-1];
                    state_n = S_INSTR_ACK;
                end else begin
                    state_n = S_DATA_ACK;
                    code_n  = shreg_q[CODE_W-1:0];
                    if (tflag_q)                 prog_n = 1'b1;
                    else if (status_i != LOCKED) wr_n   = 1'b1;
                end
            end
        end else begin
            unique case (state_q)
                S_IDLE, S_SKIP: ;
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (shreg_q[0]) begin
                            state_n = S_TX;
                            shreg_n = {status_i, wiper_i};
                        end else begin
                            state_n = S_INSTR;
                        end
                    end
                end
                S_INSTR_ACK, S_DATA_ACK: begin
                    if (scl_fall) state_n = S_DATA;
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == LAST) begin
                            state_n = S_TX_MACK;
                            cnt_n   = '0;
                        end else begin
                            shreg_n = {shreg_q[BYTE_W-2:0], 1'b0};
                            cnt_n   = cnt_q + 1'b1;
                        end
                    end
                end
                S_TX_MACK: begin
                    if (scl_rise) mack_n = ~sda_lvl;
                    if (scl_fall) begin
                        if (mack_q) begin
                            state_n = S_TX;
                            shreg_n = {status_i, wiper_i};
                        end else begin
                            state_n = S_SKIP;
                        end
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            tflag_q <= 1'b0;
            mack_q  <= 1'b0;
            code_q  <= '0;
            wr_q    <= 1'b0;
            prog_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            shreg_q <= shreg_n;
            cnt_q   <= cnt_n;
            tflag_q <= tflag_n;
            mack_q  <= mack_n;
            code_q  <= code_n;
            wr_q    <= wr_n;
            prog_q  <= prog_n;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_ADDR_ACK, S_INSTR_ACK, S_DATA_ACK: sda_oe = 1'b1;
            S_TX:                                sda_oe = ~shreg_q[BYTE_W-1];
            default:                             sda_oe = 1'b0;
        endcase
    end

    assign wr_req   = wr_q;
    assign prog_req = prog_q;
    assign req_code = code_q;

    // R10: requests are exclusive and single-cycle
    p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && prog_req));
    p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);
    p_prog_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);
    // R5: no load while the sequencer reports locked
    p_no_load_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(status_i) != LOCKED);
    // R3: a request only follows a falling SCL edge
    p_req_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || prog_req) |-> $past(scl_fall));
    // R9: STOP releases SDA
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    // R7: SDA drive changes only while SCL is low
    p_sda_change_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
    parameter int                  PREFIX_W    = 6,
    parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 6'b010110,
    parameter int                  CODE_W      = 6,
    parameter int                  STAT_W      = 2,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_pin,
    input  logic [STAT_W-1:0] status_i,
    input  logic [CODE_W-1:0] wiper_i,
    output logic              sda_oe,
    output logic              wr_req,
    output logic              prog_req,
    output logic [CODE_W-1:0] req_code
);
    localparam int NLINES = 2;
    localparam int SCL_IX = 0;
    localparam int SDA_IX = 1;

    logic [NLINES-1:0] raw, lvl, rise, fall;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        wpi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g]),
            .fall_o  (fall[g])
        );
    end

    wpi_fsm #(
        .PREFIX_W    (PREFIX_W),
        .ADDR_PREFIX (ADDR_PREFIX),
        .CODE_W      (CODE_W),
        .STAT_W      (STAT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl[SCL_IX]),
        .scl_rise (rise[SCL_IX]),
        .scl_fall (fall[SCL_IX]),
        .sda_lvl  (lvl[SDA_IX]),
        .sda_rise (rise[SDA_IX]),
        .sda_fall (fall[SDA_IX]),
        .addr_pin (addr_pin),
        .status_i (status_i),
        .wiper_i  (wiper_i),
        .sda_oe   (sda_oe),
        .wr_req   (wr_req),
        .prog_req (prog_req),
        .req_code (req_code)
    );
endmodule

// File: tb/test_wiper_i2c_slave.sv
module test_wiper_i2c_slave;
    localparam int H = 10;
    localparam int Q = 5;
    localparam logic [5:0] PFX = 6'b010110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_pin = 1'b0;
    logic [1:0] status = 2'b00;
    logic [5:0] wiper = 6'd0;
    logic       sda_oe, wr_req, prog_req;
    logic [5:0] req_code;
    wire        sda_line = sda_m & ~sda_oe;

    int vectors = 0;
    int errors  = 0;
    int wr_cnt = 0, prog_cnt = 0;
    logic [5:0] last_code = '0;
    logic oe_seen = 1'b0;

    always #5 clk = ~clk;

    wiper_i2c_slave i_wiper_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pin(addr_pin), .status_i(status), .wiper_i(wiper),
        .sda_oe(sda_oe), .wr_req(wr_req), .prog_req(prog_req), .req_code(req_code)
    );

    always @(negedge clk) begin
        if (wr_req)   begin wr_cnt++;   last_code = req_code; end
        if (prog_req) begin prog_cnt++; last_code = req_code; end
        if (sda_oe)   oe_seen = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_match(input logic [5:0] pfx, input logic pin);
        return (pfx == PFX) && (pin == addr_pin);
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] st, input logic [5:0] wp);
        return {st, wp};
    endfunction

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic put_bit(input logic b);
        w(Q); sda_m = b; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_line; w(Q); scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic do_write(input logic [5:0] pfx, input logic pin, input logic t,
                            input int n, input logic [17:0] codes,
                            output logic all_ack, output logic any_ack);
        logic a;
        bus_start();
        put_byte({pfx, pin, 1'b0}, a); all_ack = a; any_ack = a;
        put_byte({t, 7'($urandom)}, a); all_ack &= a; any_ack |= a;
        for (int k = 0; k < n; k++) begin
            put_byte({2'($urandom), codes[6*k +: 6]}, a); all_ack &= a; any_ack |= a;
        end
        bus_stop();
    endtask

    task automatic check_write(input string tag, input logic [5:0] pfx, input logic pin,
                               input logic t, input int n, input logic [17:0] codes);
        int w0, p0, ew, ep;
        logic aa, an, m;
        w0 = wr_cnt; p0 = prog_cnt; oe_seen = 1'b0;
        m = exp_match(pfx, pin);
        ew = (m && !t && status != 2'b11) ? n : 0;
        ep = (m && t) ? n : 0;
        do_write(pfx, pin, t, n, codes, aa, an);
        if (m) chk(aa, {tag, " R1 ack all bytes"}, aa, 1);
        else   chk(!an && !oe_seen, {tag, " R2 no drive"}, int'(an) | int'(oe_seen), 0);
        chk(wr_cnt - w0 == ew, {tag, " R3 R5 R6 load count"}, wr_cnt - w0, ew);
        chk(prog_cnt - p0 == ep, {tag, " R4 R6 prog count"}, prog_cnt - p0, ep);
        if (ew + ep > 0)
            chk(last_code == codes[6*(n-1) +: 6], {tag, " R3 R4 code"}, last_code, codes[6*(n-1) +: 6]);
    endtask

    task automatic check_read(input string tag, input int n);
        logic a, b;
        logic [7:0] v, e;
        bus_start();
        put_byte({PFX, addr_pin, 1'b1}, a);
        chk(a, {tag, " R1 read addr ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            e = exp_read(status, wiper);
            for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
            chk(v == e, {tag, " R7 read byte"}, v, e);
            if (k < n - 1) begin status = 2'($urandom); wiper = 6'($urandom); end
            put_bit(k == n - 1);
        end
        sda_m = 1'b1;
        bus_stop();
    endtask

    // R5 race: status changes exactly at the fall that completes the data byte
    task automatic race_write(input logic [1:0] st_late, input logic [5:0] code, input int exp_w);
        logic a;
        int w0;
        w0 = wr_cnt;
        bus_start();
        put_byte({PFX, addr_pin, 1'b0}, a);
        put_byte(8'h00, a);
        for (int i = 7; i >= 0; i--) put_bit(i < 6 ? code[i] : 1'b0);
        status = st_late;
        put_bit(1'b1);
        bus_stop();
        chk(wr_cnt - w0 == exp_w, "R5 lock race load count", wr_cnt - w0, exp_w);
        if (exp_w > 0) chk(last_code == code, "R5 lock race code", last_code, code);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        int seed;
        logic a, b;
        int w0;
        seed = int'($urandom(32'h5eed));
        w(3);
        chk(sda_oe == 0 && wr_req == 0 && prog_req == 0, "R11 reset outputs",
            {sda_oe, wr_req, prog_req}, 0);
        rst_n = 1'b1;
        w(5);
        chk(sda_oe == 0, "R11 idle after reset", sda_oe, 0);

        status = 2'b00; addr_pin = 1'b0;
        check_write("dir1", PFX, 1'b0, 1'b0, 1, 18'h0002A);
        check_write("dir2 multi", PFX, 1'b0, 1'b0, 3, {6'h3F, 6'h00, 6'h15});
        check_write("dir3 prog", PFX, 1'b0, 1'b1, 2, {6'h00, 6'h21, 6'h0C});
        status = 2'b11;
        check_write("dir4 locked", PFX, 1'b0, 1'b0, 2, {6'h00, 6'h11, 6'h22});
        status = 2'b00; addr_pin = 1'b1;
        check_write("dir5 pin miss", PFX, 1'b0, 1'b0, 1, 18'h00007);
        check_write("dir6 pfx miss", 6'b010111, 1'b1, 1'b0, 1, 18'h00007);
        check_write("dir7 pin1", PFX, 1'b1, 1'b0, 1, 18'h00033);

        status = 2'b10; wiper = 6'h25;
        check_read("dir8", 3);

        // R8: NACK ends the read; further clocks see a released line
        bus_start();
        put_byte({PFX, addr_pin, 1'b1}, a);
        for (int i = 0; i < 8; i++) get_bit(b);
        put_bit(1'b1);
        oe_seen = 1'b0;
        for (int i = 0; i < 9; i++) get_bit(b);
        chk(!oe_seen, "R8 released after NACK", oe_seen, 0);
        bus_stop();

        // R9: STOP in the middle of an address byte, then a normal write
        w0 = wr_cnt;
        bus_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        chk(sda_oe == 0, "R9 stop releases", sda_oe, 0);
        chk(wr_cnt == w0, "R9 no request after cut", wr_cnt - w0, 0);
        check_write("R9 after stop", PFX, addr_pin, 1'b0, 1, 18'h00019);

        // R9: repeated START in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        put_byte({PFX, addr_pin, 1'b0}, a);
        put_byte(8'h00, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        put_byte({PFX, addr_pin, 1'b0}, a);
        chk(a, "R9 restart address ack", a, 1);
        put_byte(8'h00, a);
        put_byte(8'h0E, a);
        bus_stop();
        chk(wr_cnt - w0 == 1, "R9 restart one load", wr_cnt - w0, 1);
        chk(last_code == 6'h0E, "R9 restart code", last_code, 6'h0E);

        // R5: lock status changes in the same window as the data decision
        status = 2'b00;
        race_write(2'b11, 6'h2D, 0);
        status = 2'b11;
        race_write(2'b00, 6'h13, 1);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [5:0] pf;
            logic pin, t;
            int n;
            addr_pin = 1'($urandom);
            status = 2'($urandom);
            wiper = 6'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                check_read("rnd read", $urandom_range(1, 3));
            end else begin
                pf = ($urandom_range(0, 5) == 0) ? 6'($urandom) : PFX;
                pin = ($urandom_range(0, 4) == 0) ? ~addr_pin : addr_pin;
                t = 1'($urandom_range(0, 3) == 0);
                n = $urandom_range(1, 3);
                check_write("rnd write R10", pf, pin, t, n, 18'($urandom));
            end
        end

        w(20);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule